// File: doc/BRIEF.md
# Cache Geometry Discovery Register Bank

This block lets software discover the cache hierarchy of a processor. It has three registers. The hierarchy map is read-only and describes up to seven cache levels, with one 3-bit kind code per level. The size selector is writable and names one cache by its level and by which side it is: instruction, or data/unified. The size report is read-only and returns the geometry of the cache that the selector currently names.

The geometry of each level is fixed when the block is elaborated, through parameter arrays. The report gives the set count minus one, the way count minus one, and the line length as log2 of the words per line minus two. Set and way counts do not have to be powers of two. The block contains no cache arrays.

Software reaches the registers through a plain register port with a 2-bit index. Reads and writes can happen in the same cycle. A register port of this kind carries no flowing data, so it has no valid/ready handshake. A read is accepted every cycle that `rd_en` is high, and it is never back-pressured.

Top module: `cid_regbank`

## Requirements
- R1: Index 0 is the hierarchy map, index 1 is the size selector, index 2 is the size report, and index 3 reads as zero. A read with `rd_en` high puts the value on `rd_data` at the next rising edge. While `rd_en` is low, `rd_data` keeps its value.
- R2: A write with `wr_en` high and `wr_addr` = 1 stores `wr_data[3:0]` in the selector. Bits [3:1] hold the level, where 0 is level 1 and 6 is level 7. Bit [0] is the side: 1 selects the instruction cache, 0 selects the data or unified cache. The selector reads back with bits [31:4] zero. Reset sets the selector to 0 (level 1, data side) and sets `rd_data` to 0.
- R3: The hierarchy map holds the kind of level L+1 in bits [3L+2:3L] and has bits [31:21] zero. The kind codes are 0 none, 1 instruction only, 2 data only, 3 split instruction and data, 4 unified, and 5 to 7 reserved.
- R4: The size report holds the set count minus one in bits [27:13]. A 256-set cache reads 0xFF, and a set count that is not a power of two, such as 1536, is reported exactly.
- R5: The size report holds the associativity minus one in bits [12:3], so a direct-mapped cache reads 0.
- R6: The size report holds log2(words per line) minus 2 in bits [2:0], so a 4-word line reads 0 and an 8-word line reads 1. Bits [31:28] are zero.
- R7: With the selector's side bit at 1, the report describes the instruction cache of the selected level. With the side bit at 0, it describes that level's data or unified cache.
- R8: If the selector's level field is 7, the selector still stores it, and the size report reads zero.
- R9: If the selected side does not exist at the selected level, the selector still stores the value and the size report reads zero. This covers a kind of none, the instruction side of a data-only or unified level, and the data side of an instruction-only level.
- R10: Writes to index 0, 2 or 3 change no register.
- R11: A read and a selector write in the same cycle return the values that were held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | 2 | Register index to read |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 2 | Register index to write |
| wr_data | input | 32 | Write data |

## Verification
Every result appears exactly one rising edge after it is requested. This covers read data, a selector update, and a size report that follows a new selection. A report that depends on a fresh selection therefore needs one cycle for the write and a second cycle for the read. The bench drives each request at a falling edge and compares `rd_data` with its model at the next falling edge. The model updates its own selector after it has computed that cycle's read, which gives the read-before-write ordering of R11. Directed cases cover every level, both sides, the reserved level, and writes to read-only indices. A stretch of random traffic follows them.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int CID_LEVELS = 7;
  localparam int CID_DW     = 32;
  localparam int KIND_W     = 3;
  localparam int SEL_W      = 4;

  localparam logic [1:0] IDX_MAP  = 2'd0;
  localparam logic [1:0] IDX_SEL  = 2'd1;
  localparam logic [1:0] IDX_SIZE = 2'd2;

  localparam logic [KIND_W-1:0] K_NONE    = 3'd0;
  localparam logic [KIND_W-1:0] K_INSN    = 3'd1;
  localparam logic [KIND_W-1:0] K_DATA    = 3'd2;
  localparam logic [KIND_W-1:0] K_SPLIT   = 3'd3;
  localparam logic [KIND_W-1:0] K_UNIFIED = 3'd4;

  localparam logic [KIND_W-1:0] DEF_KIND [CID_LEVELS] =
    '{K_SPLIT, K_UNIFIED, K_UNIFIED, K_NONE, K_NONE, K_NONE, K_NONE};
  localparam int unsigned DEF_I_SETS  [CID_LEVELS] = '{256, 64, 64, 64, 64, 64, 64};
  localparam int unsigned DEF_I_WAYS  [CID_LEVELS] = '{4, 2, 2, 2, 2, 2, 2};
  localparam int unsigned DEF_I_WORDS [CID_LEVELS] = '{8, 4, 4, 4, 4, 4, 4};
  localparam int unsigned DEF_D_SETS  [CID_LEVELS] = '{128, 1024, 1536, 64, 64, 64, 64};
  localparam int unsigned DEF_D_WAYS  [CID_LEVELS] = '{4, 8, 12, 2, 2, 2, 2};
  localparam int unsigned DEF_D_WORDS [CID_LEVELS] = '{16, 16, 16, 4, 4, 4, 4};

  function automatic logic [CID_DW-1:0] enc_size(input int unsigned sets,
                                                 input int unsigned ways,
                                                 input int unsigned words);
    logic [CID_DW-1:0] w;
    w        = '0;
    w[27:13] = 15'(sets - 1);
    w[12:3]  = 10'(ways - 1);
    w[2:0]   = 3'($clog2(words) - 2);
    return w;
  endfunction

  function automatic logic kind_has(input logic [KIND_W-1:0] k, input logic insn);
    if (insn) return (k == K_INSN) || (k == K_SPLIT);
    return (k == K_DATA) || (k == K_SPLIT) || (k == K_UNIFIED);
  endfunction
endpackage

// File: rtl/cid_sel_reg.sv
module cid_sel_reg
  import cid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] wr_val,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_hit) sel_q <= wr_val;
  end

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> sel_q == $past(wr_val));
  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(sel_q));
endmodule

// File: rtl/cid_geom_table.sv
module cid_geom_table
  import cid_pkg::*;
#(
  parameter logic [KIND_W-1:0] KIND [CID_LEVELS] = DEF_KIND,
  parameter int unsigned I_SETS  [CID_LEVELS] = DEF_I_SETS,
  parameter int unsigned I_WAYS  [CID_LEVELS] = DEF_I_WAYS,
  parameter int unsigned I_WORDS [CID_LEVELS] = DEF_I_WORDS,
  parameter int unsigned D_SETS  [CID_LEVELS] = DEF_D_SETS,
  parameter int unsigned D_WAYS  [CID_LEVELS] = DEF_D_WAYS,
  parameter int unsigned D_WORDS [CID_LEVELS] = DEF_D_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  output logic [CID_DW-1:0] size_word
);
  logic [CID_DW-1:0] slot [CID_LEVELS][2];

  for (genvar lv = 0; lv < CID_LEVELS; lv++) begin : g_lvl
    for (genvar sd = 0; sd < 2; sd++) begin : g_side
      localparam int unsigned S = (sd == 1) ? I_SETS[lv]  : D_SETS[lv];
      localparam int unsigned W = (sd == 1) ? I_WAYS[lv]  : D_WAYS[lv];
      localparam int unsigned L = (sd == 1) ? I_WORDS[lv] : D_WORDS[lv];
      assign slot[lv][sd] = kind_has(KIND[lv], 1'(sd)) ? enc_size(S, W, L) : '0;
    end
  end

  logic [2:0] lvl;
  assign lvl = sel[3:1];

  always_comb begin
    size_word = '0;
    for (int l = 0; l < CID_LEVELS; l++)
      if (lvl == 3'(l)) size_word = slot[l][sel[0]];
  end

  // R8
  rsv_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[3:1] == 3'd7) |-> (size_word == '0));
  // R6
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_word[31:28] == 4'd0);
endmodule

// File: rtl/cid_regbank.sv
module cid_regbank
  import cid_pkg::*;
#(
  parameter logic [KIND_W-1:0] KIND [CID_LEVELS] = DEF_KIND,
  parameter int unsigned I_SETS  [CID_LEVELS] = DEF_I_SETS,
  parameter int unsigned I_WAYS  [CID_LEVELS] = DEF_I_WAYS,
  parameter int unsigned I_WORDS [CID_LEVELS] = DEF_I_WORDS,
  parameter int unsigned D_SETS  [CID_LEVELS] = DEF_D_SETS,
  parameter int unsigned D_WAYS  [CID_LEVELS] = DEF_D_WAYS,
  parameter int unsigned D_WORDS [CID_LEVELS] = DEF_D_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [CID_DW-1:0] rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CID_DW-1:0] wr_data
);
  localparam int MAP_BITS = CID_LEVELS * KIND_W;

  logic [SEL_W-1:0]  sel_q;
  logic [CID_DW-1:0] size_word;
  logic [CID_DW-1:0] map_word;
  logic [CID_DW-1:0] rd_next;
  logic              sel_wr;

  assign sel_wr = wr_en && (wr_addr == IDX_SEL);

  cid_sel_reg u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (sel_wr),
    .wr_val (wr_data[SEL_W-1:0]),
    .sel_q  (sel_q)
  );

  cid_geom_table #(
    .KIND(KIND), .I_SETS(I_SETS), .I_WAYS(I_WAYS), .I_WORDS(I_WORDS),
    .D_SETS(D_SETS), .D_WAYS(D_WAYS), .D_WORDS(D_WORDS)
  ) u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_q),
    .size_word (size_word)
  );

  for (genvar lv = 0; lv < CID_LEVELS; lv++) begin : g_map
    assign map_word[lv*KIND_W +: KIND_W] = KIND[lv];
  end
  assign map_word[CID_DW-1:MAP_BITS] = '0;

  always_comb begin
    unique case (rd_addr)
      IDX_MAP:  rd_next = map_word;
      IDX_SEL:  rd_next = {{(CID_DW-SEL_W){1'b0}}, sel_q};
      IDX_SIZE: rd_next = size_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3) |=> (rd_data == '0));
  // R11
  sel_read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == IDX_SEL) |=> (rd_data == {28'd0, $past(sel_q)}));
  // R3
  map_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == IDX_MAP) |=> (rd_data[31:21] == 11'd0));
endmodule

// File: tb/tb_cid_regbank.sv
`timescale 1ns/1ps
module tb_cid_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cid_regbank dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int kinds  [7] = '{3, 4, 4, 0, 0, 0, 0};
  int isets  [7] = '{256, 64, 64, 64, 64, 64, 64};
  int iways  [7] = '{4, 2, 2, 2, 2, 2, 2};
  int iwords [7] = '{8, 4, 4, 4, 4, 4, 4};
  int dsets  [7] = '{128, 1024, 1536, 64, 64, 64, 64};
  int dways  [7] = '{4, 8, 12, 2, 2, 2, 2};
  int dwords [7] = '{16, 16, 16, 4, 4, 4, 4};

  logic [3:0]  m_sel = 4'd0;
  logic [31:0] m_rd  = 32'd0;

  function automatic int lg2(input int v);
    int n = 0;
    while ((1 << n) < v) n++;
    return n;
  endfunction

  function automatic logic [31:0] exp_size(input logic [3:0] s);
    int lvl = int'(s[3:1]);
    int k;
    bit has;
    if (lvl == 7) return 32'd0;
    k = kinds[lvl];
    has = s[0] ? (k == 1 || k == 3) : (k == 2 || k == 3 || k == 4);
    if (!has) return 32'd0;
    if (s[0]) return ((isets[lvl]-1) << 13) | ((iways[lvl]-1) << 3) | (lg2(iwords[lvl]) - 2);
    return ((dsets[lvl]-1) << 13) | ((dways[lvl]-1) << 3) | (lg2(dwords[lvl]) - 2);
  endfunction

  function automatic logic [31:0] exp_map();
    logic [31:0] m = 0;
    for (int l = 0; l < 7; l++) m = m | (kinds[l] << (3*l));
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    vectors++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  // Driven at a falling edge, compared at the next falling edge.
  task automatic step(input logic re, input logic [1:0] ra, input logic we,
                      input logic [1:0] wa, input logic [31:0] wd, input string tag);
    logic [31:0] nxt;
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    case (ra)
      2'd0: nxt = exp_map();
      2'd1: nxt = {28'd0, m_sel};
      2'd2: nxt = exp_size(m_sel);
      default: nxt = 32'd0;
    endcase
    if (re) m_rd = nxt;
    if (we && wa == 2'd1) m_sel = wd[3:0];
    @(negedge clk);
    check(tag, m_rd);
  endtask

  task automatic sel_then_size(input logic [3:0] s, input string tag);
    step(1'b0, 2'd0, 1'b1, 2'd1, {28'hABCDEF0, s}, tag);
    step(1'b1, 2'd2, 1'b0, 2'd0, 32'd0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset rd_data", 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 2'd1, 1'b0, 2'd0, 32'd0, "R2 reset selector");
    step(1'b0, 2'd0, 1'b0, 2'd0, 32'd0, "R1 hold without read");
    step(1'b1, 2'd0, 1'b0, 2'd0, 32'd0, "R3 hierarchy map");
    step(1'b1, 2'd3, 1'b0, 2'd0, 32'd0, "R1 index 3 zero");
    step(1'b1, 2'd2, 1'b0, 2'd0, 32'd0, "R6 L1 data after reset");
    sel_then_size(4'b0001, "R4 L1 instruction 256 sets");
    sel_then_size(4'b0000, "R5 L1 data");
    sel_then_size(4'b0010, "R4 L2 unified");
    sel_then_size(4'b0100, "R4 L3 1536 sets");
    sel_then_size(4'b0011, "R9 L2 instruction side absent");
    sel_then_size(4'b0110, "R9 L4 no cache");
    sel_then_size(4'b1101, "R7 L7 none insn");
    sel_then_size(4'b1110, "R8 reserved level data");
    step(1'b1, 2'd1, 1'b0, 2'd0, 32'd0, "R8 reserved level stored");
    sel_then_size(4'b1111, "R8 reserved level insn");
    sel_then_size(4'b0001, "R7 back to L1 instruction");
    step(1'b0, 2'd0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R10 write map");
    step(1'b0, 2'd0, 1'b1, 2'd2, 32'h0000_0000, "R10 write size");
    step(1'b0, 2'd0, 1'b1, 2'd3, 32'h0000_0006, "R10 write index 3");
    step(1'b1, 2'd1, 1'b0, 2'd0, 32'd0, "R10 selector unchanged");
    step(1'b1, 2'd0, 1'b0, 2'd0, 32'd0, "R10 map unchanged");
    step(1'b1, 2'd2, 1'b0, 2'd0, 32'd0, "R10 size unchanged");
    step(1'b1, 2'd1, 1'b1, 2'd1, 32'h0000_0004, "R11 read old selector");
    step(1'b1, 2'd2, 1'b1, 2'd1, 32'h0000_0000, "R11 read old size");
    step(1'b1, 2'd2, 1'b0, 2'd0, 32'd0, "R11 new size");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], r[2:1], r[3], r[5:4], {r[31:8], r[11:8]}, "R1 random traffic");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule